// File: doc/BRIEF.md
# Paged Address Translator with Lookaside Cache

This block converts 32-bit virtual addresses into 20-bit physical addresses for a small paged memory system with 4 KB pages. A requester presents a virtual address. The low 12 bits pass through unchanged. The upper 20 bits form a page number, which is compared in parallel against every tag of an eight-entry, fully associative translation cache. When an entry matches, the response comes back in the same cycle.

When no entry matches, the block walks a single-level page table held in an on-block synchronous memory. It reads the entry, completes the request and installs the new mapping in the cache. A page-table entry marked invalid produces a fault response instead of an address.

A host loads page-table entries, supplies the table base for the active process and writes cache slots directly. A slot written this way can be locked so that replacement leaves it alone. A flush input empties every slot that is not locked. Two counters report how many requests hit and how many missed.

Top module: `paged_xlate`

## Requirements
- R1: The physical address is the 8-bit frame number in bits 19:12 followed by virtual address bits 11:0, unchanged.
- R2: When a valid cache entry's tag equals the page number, resp_valid rises in the same cycle as req_valid, with that entry's frame. hit_count then increases by one.
- R3: A miss drops req_ready for two cycles. resp_valid is asserted two cycles after the request cycle, and miss_count increases by one.
- R4: A successful walk installs its page/frame pair, so a later request to the same page hits.
- R5: Tags compare all 20 page-number bits. Two pages that share the low 10 bits are distinct entries.
- R6: When the page-table entry's valid bit is 0, the response has resp_fault=1 and resp_paddr=0, and nothing is installed. A repeat request misses again.
- R7: The replacement victim is the first unlocked slot at or after a round-robin pointer, wrapping around. The pointer then moves one past the victim, and a locked slot is never replaced.
- R8: When all eight slots are locked, a miss still completes normally but installs nothing.
- R9: In one cycle, tlb_flush invalidates every unlocked slot, and locked slots stay valid.
- R10: A host write to slot tlb_wr_slot makes that page/frame mapping valid from the next cycle, and tlb_wr_pin=1 locks the slot.
- R11: The walk reads page-table index (pt_base + page_number[9:0]) mod 1024.
- R12: After reset, req_ready=1, resp_valid=0, both counters are 0 and no cache slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present. Held until resp_valid |
| req_vaddr | input | 32 | Virtual address. Held with req_valid |
| req_ready | output | 1 | Block is idle and able to look up |
| resp_valid | output | 1 | Response present this cycle |
| resp_paddr | output | 20 | Physical address. Zero on fault |
| resp_fault | output | 1 | Page marked invalid |
| pt_base | input | 10 | Page-table base of the active process |
| pt_wr_en | input | 1 | Page-table write strobe |
| pt_wr_idx | input | 10 | Page-table write index |
| pt_wr_frame | input | 8 | Frame number to store |
| pt_wr_valid | input | 1 | Valid bit to store |
| tlb_wr_en | input | 1 | Direct cache slot write strobe |
| tlb_wr_slot | input | 3 | Slot to write |
| tlb_wr_vpn | input | 20 | Page number for the slot |
| tlb_wr_frame | input | 8 | Frame for the slot |
| tlb_wr_pin | input | 1 | Lock the slot against replacement |
| tlb_flush | input | 1 | Invalidate all unlocked slots |
| hit_count | output | 16 | Requests served from the cache |
| miss_count | output | 16 | Requests that walked the table |

## Verification
The bench first runs repeated requests to one page with different offsets. These separate a cached hit, which responds in zero extra cycles, from a walk, which takes two, and show that the offset passes through. It then sends a page whose high page-number bits differ but whose low table bits are equal, which exposes a tag that compares too few bits. It also repeats a request to an invalid page, which shows whether a fault wrongly installs a mapping. Finally, it fills past capacity with and without locked slots and with every slot locked, and flushes around a locked entry. These cases pin down victim order, whether locks are honoured and which slots a flush clears.

// File: rtl/paged_xlate_pkg.sv
package paged_xlate_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_READ = 2'd1,
    WALK_FILL = 2'd2
  } walk_state_e;

endpackage

// File: rtl/xlate_victim_pick.sv
module xlate_victim_pick #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]  locked,
  input  logic [SLOT_W-1:0] start,
  output logic [SLOT_W-1:0] victim,
  output logic              found
);

  // Scan from start+SLOTS-1 down to start so the nearest free slot wins.
  always_comb begin
    victim = start;
    found  = 1'b0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (!locked[SLOT_W'(int'(start) + k)]) begin
        victim = SLOT_W'(int'(start) + k);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xlate_pt_mem.sv
module xlate_pt_mem #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 9,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_idx] <= wr_data;
    end
    rd_data <= store[rd_idx];
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int SLOTS  = 8,
  parameter int VPN_W  = 20,
  parameter int FRM_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  look_vpn,
  output logic              look_hit,
  output logic [FRM_W-1:0]  look_frame,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [FRM_W-1:0]  fill_frame,
  input  logic              host_en,
  input  logic [SLOT_W-1:0] host_slot,
  input  logic [VPN_W-1:0]  host_vpn,
  input  logic [FRM_W-1:0]  host_frame,
  input  logic              host_lock,
  input  logic              flush
);

  logic [SLOTS-1:0]  valid_q, valid_d;
  logic [SLOTS-1:0]  lock_q, lock_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [VPN_W-1:0]  tag_q [SLOTS];
  logic [FRM_W-1:0]  frm_q [SLOTS];
  logic [SLOTS-1:0]  ent_we;
  logic [VPN_W-1:0]  ent_tag;
  logic [FRM_W-1:0]  ent_frm [SLOTS];
  logic [VPN_W-1:0]  ent_tagv [SLOTS];
  logic [SLOTS-1:0]  match;
  logic [SLOT_W-1:0] victim;
  logic              free_found;
  logic              fill_go;

  xlate_victim_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .locked (lock_q),
    .start  (ptr_q),
    .victim (victim),
    .found  (free_found)
  );

  // Parallel tag compare, one comparator per slot.
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == look_vpn);
  end

  always_comb begin
    look_hit   = |match;
    look_frame = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (match[k]) look_frame = frm_q[k];
    end
  end

  assign fill_go = fill_en && free_found;
  assign ent_tag = fill_vpn;

  // Next state: fill first, then flush, then host write takes precedence.
  always_comb begin
    valid_d = valid_q;
    lock_d  = lock_q;
    ptr_d   = fill_go ? SLOT_W'(victim + 1'b1) : ptr_q;
    for (int k = 0; k < SLOTS; k++) begin
      ent_we[k]   = 1'b0;
      ent_tagv[k] = ent_tag;
      ent_frm[k]  = fill_frame;
      if (fill_go && victim == SLOT_W'(k)) begin
        valid_d[k] = 1'b1;
        ent_we[k]  = 1'b1;
      end
      if (flush && !lock_q[k]) begin
        valid_d[k] = 1'b0;
      end
      if (host_en && host_slot == SLOT_W'(k)) begin
        valid_d[k]  = 1'b1;
        lock_d[k]   = host_lock;
        ent_we[k]   = 1'b1;
        ent_tagv[k] = host_vpn;
        ent_frm[k]  = host_frame;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      lock_q  <= lock_d;
      ptr_q   <= ptr_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (ent_we[g]) begin
        tag_q[g] <= ent_tagv[g];
        frm_q[g] <= ent_frm[g];
      end
    end
  end

  // R7: the picker never hands a locked slot to a fill
  assert_fill_avoids_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |-> !lock_q[victim]);

  // R9: after a flush only locked slots can remain valid
  assert_flush_clears_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !host_en) |=> ((valid_q & ~lock_q) == '0));

  // R9: locked slots keep their valid state across a flush
  assert_flush_keeps_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !host_en) |=> ((valid_q & lock_q) == $past(valid_q & lock_q)));

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
  import paged_xlate_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int FRM_W  = 8,
  parameter int SLOTS  = 8,
  parameter int PT_W   = 10,
  parameter int CNT_W  = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = FRM_W + OFF_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PTE_W  = FRM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault,
  input  logic [PT_W-1:0]   pt_base,
  input  logic              pt_wr_en,
  input  logic [PT_W-1:0]   pt_wr_idx,
  input  logic [FRM_W-1:0]  pt_wr_frame,
  input  logic              pt_wr_valid,
  input  logic              tlb_wr_en,
  input  logic [SLOT_W-1:0] tlb_wr_slot,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [FRM_W-1:0]  tlb_wr_frame,
  input  logic              tlb_wr_pin,
  input  logic              tlb_flush,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  walk_state_e       state_q, state_d;
  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [PTE_W-1:0]  pte_q, pte_d;
  logic [CNT_W-1:0]  hits_q, hits_d;
  logic [CNT_W-1:0]  miss_q, miss_d;
  logic [VPN_W-1:0]  req_vpn;
  logic [PT_W-1:0]   rd_idx;
  logic [PTE_W-1:0]  rd_pte;
  logic              look_hit;
  logic [FRM_W-1:0]  look_frame;
  logic              hit_take;
  logic              walk_start;
  logic              fill_en;
  logic              pte_ok;

  assign req_vpn    = req_vaddr[VA_W-1:OFF_W];
  assign rd_idx     = PT_W'(pt_base + req_vpn[PT_W-1:0]);
  assign hit_take   = (state_q == WALK_IDLE) && req_valid && look_hit;
  assign walk_start = (state_q == WALK_IDLE) && req_valid && !look_hit;
  assign pte_ok     = pte_q[FRM_W];
  assign fill_en    = (state_q == WALK_FILL) && pte_ok;

  xlate_pt_mem #(.IDX_W(PT_W), .DATA_W(PTE_W)) u_table (
    .clk     (clk),
    .wr_en   (pt_wr_en),
    .wr_idx  (pt_wr_idx),
    .wr_data ({pt_wr_valid, pt_wr_frame}),
    .rd_idx  (rd_idx),
    .rd_data (rd_pte)
  );

  xlate_cache #(.SLOTS(SLOTS), .VPN_W(VPN_W), .FRM_W(FRM_W)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vpn   (req_vpn),
    .look_hit   (look_hit),
    .look_frame (look_frame),
    .fill_en    (fill_en),
    .fill_vpn   (vpn_q),
    .fill_frame (pte_q[FRM_W-1:0]),
    .host_en    (tlb_wr_en),
    .host_slot  (tlb_wr_slot),
    .host_vpn   (tlb_wr_vpn),
    .host_frame (tlb_wr_frame),
    .host_lock  (tlb_wr_pin),
    .flush      (tlb_flush)
  );

  always_comb begin
    state_d = state_q;
    vpn_d   = vpn_q;
    off_d   = off_q;
    pte_d   = pte_q;
    hits_d  = hits_q + CNT_W'(hit_take);
    miss_d  = miss_q + CNT_W'(walk_start);
    unique case (state_q)
      WALK_IDLE: if (walk_start) begin
        state_d = WALK_READ;
        vpn_d   = req_vpn;
        off_d   = req_vaddr[OFF_W-1:0];
      end
      WALK_READ: begin
        state_d = WALK_FILL;
        pte_d   = rd_pte;
      end
      WALK_FILL: state_d = WALK_IDLE;
      default:   state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      hits_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      hits_q  <= hits_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (walk_start) begin
      vpn_q <= vpn_d;
      off_q <= off_d;
    end
    if (state_q == WALK_READ) begin
      pte_q <= pte_d;
    end
  end

  always_comb begin
    req_ready  = (state_q == WALK_IDLE);
    resp_valid = hit_take || (state_q == WALK_FILL);
    resp_fault = (state_q == WALK_FILL) && !pte_ok;
    resp_paddr = '0;
    if (hit_take) begin
      resp_paddr = {look_frame, req_vaddr[OFF_W-1:0]};
    end else if (fill_en) begin
      resp_paddr = {pte_q[FRM_W-1:0], off_q};
    end
  end

  assign hit_count  = hits_q;
  assign miss_count = miss_q;

  // R6: a faulting response carries no address
  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  // R3: a request that is not answered at once is answered two cycles later
  assert_miss_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !resp_valid) |=> (!req_ready && !resp_valid) ##1 resp_valid);

  // R2: the hit counter only ever steps by one
  assert_hit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1));

  // R3: the miss counter only ever steps by one
  assert_miss_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));

endmodule

// File: tb/paged_xlate_test.sv
`timescale 1ns/1ps
module paged_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_ready;
  logic        resp_valid;
  logic [19:0] resp_paddr;
  logic        resp_fault;
  logic [9:0]  pt_base;
  logic        pt_wr_en;
  logic [9:0]  pt_wr_idx;
  logic [7:0]  pt_wr_frame;
  logic        pt_wr_valid;
  logic        tlb_wr_en;
  logic [2:0]  tlb_wr_slot;
  logic [19:0] tlb_wr_vpn;
  logic [7:0]  tlb_wr_frame;
  logic        tlb_wr_pin;
  logic        tlb_flush;
  logic [15:0] hit_count;
  logic [15:0] miss_count;

  int checks = 0;
  int fails  = 0;
  int exp_hits = 0;
  int exp_miss = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  paged_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .pt_base(pt_base), .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx),
    .pt_wr_frame(pt_wr_frame), .pt_wr_valid(pt_wr_valid),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot), .tlb_wr_vpn(tlb_wr_vpn),
    .tlb_wr_frame(tlb_wr_frame), .tlb_wr_pin(tlb_wr_pin), .tlb_flush(tlb_flush),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // Vector table: virtual address and whether a cache hit is expected.
  localparam int NV = 8;
  localparam logic [31:0] TV_VA [NV] = '{
    32'h0000_1ABC, 32'h0000_1004, 32'h0000_3010, 32'h0000_3020,
    32'h0000_2FFF, 32'h0000_1777, 32'h0040_1123, 32'h0000_2000
  };
  localparam bit TV_HIT [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  // Page-table contents the bench loads, and the expected walk result.
  function automatic logic [7:0] tab_frame(input logic [9:0] i);
    return i[7:0] ^ {i[9:8], 6'b0} ^ 8'h5A;
  endfunction
  function automatic bit tab_bad(input logic [9:0] i);
    return (int'(i) % 7) == 3;
  endfunction
  function automatic logic [9:0] tab_idx(input logic [31:0] va);
    return 10'(pt_base + va[21:12]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] va, input bit exp_hit, input bit exp_fault,
                        input logic [7:0] exp_frm, input string req);
    int lat;
    logic [19:0] exp_pa;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    #1;
    lat = 0;
    while (!resp_valid && lat < 8) begin
      @(negedge clk);
      #1;
      lat++;
    end
    exp_pa = exp_fault ? 20'h0 : {exp_frm, va[11:0]};
    chk(resp_valid, req, "resp_valid", 32'(resp_valid), 32'd1);
    chk(lat == (exp_hit ? 0 : 2), req, "latency", 32'(lat), exp_hit ? 32'd0 : 32'd2);
    chk(resp_paddr == exp_pa && resp_fault == exp_fault, req, "fault,paddr",
        {11'b0, resp_fault, resp_paddr}, {11'b0, exp_fault, exp_pa});
    if (exp_hit) exp_hits++; else exp_miss++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Request whose expected result comes from the loaded page table.
  task automatic walk_req(input logic [31:0] va, input bit exp_hit, input string req);
    logic [9:0] i;
    i = tab_idx(va);
    do_req(va, exp_hit, tab_bad(i), tab_frame(i), req);
  endtask

  task automatic slot_put(input int slot, input logic [19:0] vpn, input logic [7:0] frm,
                          input bit lock);
    @(negedge clk);
    tlb_wr_en = 1'b1; tlb_wr_slot = 3'(slot); tlb_wr_vpn = vpn;
    tlb_wr_frame = frm; tlb_wr_pin = lock;
    @(negedge clk);
    tlb_wr_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    tlb_flush = 1'b1;
    @(negedge clk);
    tlb_flush = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_hits = 0;
    exp_miss = 0;
    #1;
    chk(req_ready == 1'b1, "R12", "req_ready", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R12", "resp_valid", 32'(resp_valid), 32'd0);
    chk(hit_count == 0 && miss_count == 0, "R12", "counters",
        {hit_count, miss_count}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; pt_base = '0;
    pt_wr_en = 1'b0; pt_wr_idx = '0; pt_wr_frame = '0; pt_wr_valid = 1'b0;
    tlb_wr_en = 1'b0; tlb_wr_slot = '0; tlb_wr_vpn = '0; tlb_wr_frame = '0;
    tlb_wr_pin = 1'b0; tlb_flush = 1'b0;
    do_reset();

    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      pt_wr_en = 1'b1; pt_wr_idx = 10'(i);
      pt_wr_frame = tab_frame(10'(i)); pt_wr_valid = !tab_bad(10'(i));
    end
    @(negedge clk);
    pt_wr_en = 1'b0;

    // R1 R2 R3 R4 R5 R6: table walk (fault rows are pages 3; page 0x401 shares low bits with page 1)
    for (int v = 0; v < NV; v++) begin
      walk_req(TV_VA[v], TV_HIT[v], "R1_R2_R3_R4_R5_R6");
    end
    #1;
    chk(hit_count == 16'(exp_hits), "R2", "hit_count", 32'(hit_count), 32'(exp_hits));
    chk(miss_count == 16'(exp_miss), "R3", "miss_count", 32'(miss_count), 32'(exp_miss));

    // R7: fill slots 3..7, then the pointer wraps and page 0x10 replaces page 1 in slot 0
    walk_req(32'h0000_8010, 1'b0, "R7");
    walk_req(32'h0000_9010, 1'b0, "R7");
    walk_req(32'h0000_B010, 1'b0, "R7");
    walk_req(32'h0000_C010, 1'b0, "R7");
    walk_req(32'h0000_F010, 1'b0, "R7");
    walk_req(32'h0001_0010, 1'b0, "R7");
    walk_req(32'h0000_2468, 1'b1, "R7");
    walk_req(32'h0000_1468, 1'b0, "R7");

    // R10 R9: locked host entry, then flush
    slot_put(2, 20'h00300, 8'hC3, 1'b1);
    do_req(32'h0030_0456, 1'b1, 1'b0, 8'hC3, "R10");
    do_flush();
    do_req(32'h0030_0789, 1'b1, 1'b0, 8'hC3, "R9");
    walk_req(32'h0001_0020, 1'b0, "R9");

    // R11: a different table base selects a different entry for page 1
    do_flush();
    pt_base = 10'h100;
    walk_req(32'h0000_1ABC, 1'b0, "R11");
    pt_base = 10'h000;

    // R12 R7: after reset the cache is empty; a locked slot 0 survives replacement
    do_reset();
    walk_req(32'h0030_0111, 1'b0, "R12");
    slot_put(0, 20'h00500, 8'h99, 1'b1);
    walk_req(32'h0000_1000, 1'b0, "R7");
    walk_req(32'h0000_2000, 1'b0, "R7");
    walk_req(32'h0000_4000, 1'b0, "R7");
    walk_req(32'h0000_5000, 1'b0, "R7");
    walk_req(32'h0000_6000, 1'b0, "R7");
    walk_req(32'h0000_8000, 1'b0, "R7");
    walk_req(32'h0000_9000, 1'b0, "R7");
    walk_req(32'h0000_B000, 1'b0, "R7");
    walk_req(32'h0000_2ABC, 1'b1, "R7");
    do_req(32'h0050_0ABC, 1'b1, 1'b0, 8'h99, "R7");
    walk_req(32'h0000_1ABC, 1'b0, "R7");

    // R8: every slot locked, a miss completes but installs nothing
    do_reset();
    for (int s = 0; s < 8; s++) begin
      slot_put(s, 20'h00600 + 20'(s), 8'h80 + 8'(s), 1'b1);
    end
    walk_req(32'h0000_1234, 1'b0, "R8");
    walk_req(32'h0000_1234, 1'b0, "R8");
    do_req(32'h0060_7321, 1'b1, 1'b0, 8'h87, "R8");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog cycles=%0d expected=completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule